// File: doc/BRIEF.md
# Controller Register Space Access Checker

This block sits between the CPU bus and the register and buffer storage of a bus controller. For every access it classifies the 32-bit word offset into one of five regions and decides whether the access is legal: control/status registers, active message buffers, spare general-purpose RAM, individual receive-mask words, or reserved space. The storage arrays use the region select to steer the access. An access error ends the transfer with an error response.

The decision depends on four things: the programmed highest active buffer index, the privilege level of the access, freeze mode and the individual-mask enable. Buffer and mask words that lie above the active buffer count are not errors. They are decoded as spare RAM, so software can use unused buffer space as plain memory. The result is registered and appears one cycle after the request. Reads and writes are judged alike.

Top module: `acc_space_checker`

## Requirements
- R1: After reset, rsp_valid and rsp_err are 0 and rsp_region is 0. A request sampled at a clock edge is answered with rsp_valid=1 after the next edge. A cycle with no request yields rsp_valid=0, rsp_err=0 and rsp_region=0.
- R2: Aligned offsets 0x000 to 0x05F decode as region 0 (control). The supervisor map marks word offsets 0 to 3 and 8 to 15 as supervisor-only (default bitmap 24'h00FF0F, bit n = word n). A user-mode access (req_user=1) to a marked word gives rsp_err=1. Every other control access gives no error.
- R3: Any offset with bits [1:0] not equal to 00 gives region 4 (reserved) and rsp_err=1, whatever the offset.
- R4: Aligned offsets 0x060 to 0x07F give region 4 with rsp_err=1.
- R5: Buffer n occupies 0x080+16n to 0x08F+16n, for n from 0 to 63. When n is not above the active index, the access decodes as region 1 (message buffer) with no error. The active index is max_idx, clamped to 63.
- R6: A buffer word with n above the active index decodes as region 2 (spare RAM) with no error. With max_idx=0, this covers 0x090 to 0x47F.
- R7: Aligned offsets 0x480 to 0x87F, and 0x980 up to the top of the address space, give region 4 with rsp_err=1.
- R8: Mask word k sits at 0x880+4k, for k from 0 to 63. When k is not above the active index, it decodes as region 3 (individual mask). rsp_err=1 unless both freeze=1 and mask_en=1.
- R9: A mask word with k above the active index decodes as region 2 (spare RAM), under the same freeze and mask-enable error rule as R8. With max_idx=0, this covers 0x884 to 0x97F.
- R10: req_write has no influence on rsp_err or rsp_region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 12 | Byte offset into the controller space |
| req_write | input | 1 | 1 for write, 0 for read |
| req_user | input | 1 | 1 when the access is made in user mode |
| freeze | input | 1 | Controller is in freeze mode |
| mask_en | input | 1 | Individual receive masks enabled |
| max_idx | input | 6 | Highest active message buffer index |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access error |
| rsp_region | output | 3 | 0 control, 1 buffer, 2 spare RAM, 3 mask, 4 reserved |

## Verification
Spare-RAM redirection and the mask-access rules apply in the same cycle when an access hits a mask word above the active index. The result must be region 2, and it must still carry an error unless both freeze and mask enable are set. The bench provokes this with directed accesses to 0x884 and 0x97C under every freeze and mask-enable combination. It also uses random traffic in which max_idx changes on the same cycle as the access. Each registered result is compared to a behavioural model evaluated on that cycle's inputs.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_MBUF  = 3'd1,
        RG_SPARE = 3'd2,
        RG_IMASK = 3'd3,
        RG_RSVD  = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        ZN_CTRL,
        ZN_SMB,
        ZN_MBUF,
        ZN_GAP,
        ZN_IMASK,
        ZN_TOP,
        ZN_MISAL
    } zone_e;

    typedef struct packed {
        logic    valid;
        logic    err;
        region_e region;
    } rsp_s;

endpackage

// File: rtl/acc_addr_decode.sv
module acc_addr_decode
    import acc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_MB = 64,
    parameter int IDX_W  = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output zone_e             zone_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [31:0] CTRL_END  = 32'h060;
    localparam logic [31:0] MB_BASE   = 32'h080;
    localparam logic [31:0] MB_END    = MB_BASE + 32'(NUM_MB) * 32'd16;
    localparam logic [31:0] MASK_BASE = 32'h880;
    localparam logic [31:0] MASK_END  = MASK_BASE + 32'(NUM_MB) * 32'd4;

    logic [31:0] a;
    logic [31:0] mb_off;
    logic [31:0] mk_off;

    assign a      = 32'(addr_i);
    assign mb_off = (a - MB_BASE) >> 4;
    assign mk_off = (a - MASK_BASE) >> 2;

    always_comb begin
        zone_o = ZN_TOP;
        idx_o  = '0;
        if (addr_i[1:0] != 2'b00) begin
            zone_o = ZN_MISAL;
        end else if (a < CTRL_END) begin
            zone_o = ZN_CTRL;
            idx_o  = IDX_W'(a >> 2);
        end else if (a < MB_BASE) begin
            zone_o = ZN_SMB;
        end else if (a < MB_END) begin
            zone_o = ZN_MBUF;
            idx_o  = IDX_W'(mb_off);
        end else if (a < MASK_BASE) begin
            zone_o = ZN_GAP;
        end else if (a < MASK_END) begin
            zone_o = ZN_IMASK;
            idx_o  = IDX_W'(mk_off);
        end
    end
endmodule

// File: rtl/acc_rule_check.sv
module acc_rule_check
    import acc_pkg::*;
#(
    parameter int          NUM_MB  = 64,
    parameter int          IDX_W   = 7,
    parameter int          MAXI_W  = 6,
    parameter logic [23:0] SUP_MAP = 24'h00FF0F
) (
    input  zone_e             zone_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [MAXI_W-1:0] max_idx_i,
    input  logic              user_i,
    input  logic              freeze_i,
    input  logic              mask_en_i,
    output region_e           region_o,
    output logic              err_o
);
    localparam int CTRL_WORDS = 24;

    logic [CTRL_WORDS-1:0] sup_word;
    logic                  sup_hit;
    logic [31:0]           last_w;
    logic                  active;
    logic                  mask_ok;

    for (genvar w = 0; w < CTRL_WORDS; w++) begin : g_sup
        assign sup_word[w] = SUP_MAP[w] && (idx_i == IDX_W'(w));
    end

    assign sup_hit = |sup_word;
    assign last_w  = (32'(max_idx_i) >= 32'(NUM_MB)) ? 32'(NUM_MB - 1) : 32'(max_idx_i);
    assign active  = 32'(idx_i) <= last_w;
    assign mask_ok = freeze_i && mask_en_i;

    always_comb begin
        region_o = RG_RSVD;
        err_o    = 1'b1;
        unique case (zone_i)
            ZN_CTRL: begin
                region_o = RG_CTRL;
                err_o    = user_i && sup_hit;
            end
            ZN_MBUF: begin
                region_o = active ? RG_MBUF : RG_SPARE;
                err_o    = 1'b0;
            end
            ZN_IMASK: begin
                region_o = active ? RG_IMASK : RG_SPARE;
                err_o    = !mask_ok;
            end
            default: begin
                region_o = RG_RSVD;
                err_o    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/acc_space_checker.sv
module acc_space_checker
    import acc_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          NUM_MB  = 64,
    parameter int          MAXI_W  = 6,
    parameter logic [23:0] SUP_MAP = 24'h00FF0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              freeze,
    input  logic              mask_en,
    input  logic [MAXI_W-1:0] max_idx,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [2:0]        rsp_region
);
    localparam int IDX_RAW = $clog2(NUM_MB) + 1;
    localparam int IDX_W   = (IDX_RAW > 5) ? IDX_RAW : 5;

    zone_e            zone;
    logic [IDX_W-1:0] idx;
    region_e          region_c;
    logic             err_c;
    rsp_s             rsp_d, rsp_q;

    acc_addr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_MB (NUM_MB),
        .IDX_W  (IDX_W)
    ) i_decode (
        .addr_i (req_addr),
        .zone_o (zone),
        .idx_o  (idx)
    );

    acc_rule_check #(
        .NUM_MB  (NUM_MB),
        .IDX_W   (IDX_W),
        .MAXI_W  (MAXI_W),
        .SUP_MAP (SUP_MAP)
    ) i_rules (
        .zone_i    (zone),
        .idx_i     (idx),
        .max_idx_i (max_idx),
        .user_i    (req_user),
        .freeze_i  (freeze),
        .mask_en_i (mask_en),
        .region_o  (region_c),
        .err_o     (err_c)
    );

    always_comb begin
        rsp_d = '{valid: 1'b0, err: 1'b0, region: RG_CTRL};
        if (req_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.err    = err_c;
            rsp_d.region = region_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{valid: 1'b0, err: 1'b0, region: RG_CTRL};
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_err    = rsp_q.err;
    assign rsp_region = rsp_q.region;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err));

    // R1
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_region == 3'd4));

    // R8
    imask_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !freeze && zone == ZN_IMASK) |=> rsp_err);

    // R5
    mbuf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == 3'd1) |-> !rsp_err);

    // R2
    super_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && zone == ZN_CTRL) |=> !rsp_err);

    // R10
    write_mask_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && freeze && mask_en && zone == ZN_IMASK) |=> !rsp_err);

endmodule

// File: tb/test_acc_space_checker.sv
module test_acc_space_checker;

    localparam logic [23:0] SUPV = 24'h00FF0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        freeze = 1'b0;
    logic        mask_en = 1'b0;
    logic [5:0]  max_idx = '0;
    logic        rsp_valid, rsp_err;
    logic [2:0]  rsp_region;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit    v;
        bit    e;
        int    rg;
        string tag;
    } exp_t;
    exp_t pend[$];

    always #10 clk = ~clk;

    acc_space_checker i_acc_space_checker (
        .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_user,
        .freeze, .mask_en, .max_idx, .rsp_valid, .rsp_err, .rsp_region
    );

    function automatic exp_t model(input bit v, input int a, input bit u,
                                   input bit f, input bit m, input int mx, input string note);
        exp_t r;
        int   last = (mx > 63) ? 63 : mx;
        int   n;
        r.v = v; r.e = 1'b0; r.rg = 0; r.tag = "R1";
        if (!v) return r;
        if (a % 4 != 0) begin
            r.e = 1; r.rg = 4; r.tag = "R3";
        end else if (a < 'h60) begin
            r.rg = 0; r.e = u && SUPV[a / 4]; r.tag = "R2";
        end else if (a < 'h80) begin
            r.e = 1; r.rg = 4; r.tag = "R4";
        end else if (a < 'h480) begin
            n = (a - 'h80) / 16;
            r.rg = (n <= last) ? 1 : 2;
            r.tag = (n <= last) ? "R5" : "R6";
        end else if (a < 'h880) begin
            r.e = 1; r.rg = 4; r.tag = "R7";
        end else if (a < 'h980) begin
            n = (a - 'h880) / 4;
            r.rg = (n <= last) ? 3 : 2;
            r.e = !(f && m);
            r.tag = (n <= last) ? "R8" : "R9";
        end else begin
            r.e = 1; r.rg = 4; r.tag = "R7";
        end
        if (note.len() > 0) r.tag = {r.tag, " ", note};
        return r;
    endfunction

    task automatic drive(input bit v, input int a, input bit w, input bit u,
                         input bit f, input bit m, input int mx, input string note);
        @(negedge clk);
        if (pend.size() > 0) begin
            exp_t x = pend.pop_front();
            checks++;
            if (rsp_valid !== x.v || rsp_err !== x.e || int'(rsp_region) != x.rg) begin
                errors++;
                $display("FAIL %s: got valid=%0b err=%0b region=%0d, expected valid=%0b err=%0b region=%0d",
                         x.tag, rsp_valid, rsp_err, rsp_region, x.v, x.e, x.rg);
            end
        end
        req_valid = v; req_addr = 12'(a); req_write = w; req_user = u;
        freeze = f; mask_en = m; max_idx = 6'(mx);
        pend.push_back(model(v, a, u, f, m, mx, note));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_region !== 3'd0) begin
            errors++;
            $display("FAIL R1 reset: got %0b %0b %0d, expected 0 0 0", rsp_valid, rsp_err, rsp_region);
        end
        rst_n = 1'b1;
        // R1 idle cycle, R2 control words in both modes
        drive(0, 'h000, 0, 0, 0, 0, 0, "idle");
        drive(1, 'h000, 0, 1, 0, 0, 0, "");
        drive(1, 'h000, 0, 0, 0, 0, 0, "");
        drive(1, 'h010, 0, 1, 0, 0, 0, "");
        drive(1, 'h020, 1, 1, 0, 0, 0, "");
        drive(1, 'h05C, 0, 1, 0, 0, 0, "");
        // R3 misaligned, R4 reserved head, R7 gaps
        drive(1, 'h081, 0, 0, 1, 1, 63, "");
        drive(1, 'h882, 1, 0, 1, 1, 63, "");
        drive(1, 'h060, 0, 0, 1, 1, 63, "");
        drive(1, 'h07C, 1, 0, 1, 1, 63, "");
        drive(1, 'h480, 0, 0, 1, 1, 63, "");
        drive(1, 'h87C, 0, 0, 1, 1, 63, "");
        drive(1, 'h980, 0, 0, 1, 1, 63, "");
        drive(1, 'hFFC, 0, 0, 1, 1, 63, "");
        // R5 / R6 boundary around max_idx=0
        drive(1, 'h080, 0, 1, 0, 0, 0, "");
        drive(1, 'h08C, 0, 1, 0, 0, 0, "");
        drive(1, 'h090, 0, 1, 0, 0, 0, "");
        drive(1, 'h47C, 1, 1, 0, 0, 0, "");
        drive(1, 'h47C, 0, 0, 0, 0, 63, "");
        // R8 / R9 in all freeze and enable combinations, same cycle as redirect
        for (int c = 0; c < 4; c++) begin
            drive(1, 'h880, 0, 0, c[0], c[1], 0, "");
            drive(1, 'h884, 0, 0, c[0], c[1], 0, "");
            drive(1, 'h97C, 1, 0, c[0], c[1], 0, "");
        end
        // R10 same access as read and as write
        drive(1, 'h8A0, 0, 0, 1, 1, 20, "R10");
        drive(1, 'h8A0, 1, 0, 1, 1, 20, "R10");
        drive(1, 'h8A0, 1, 0, 0, 1, 20, "R10");
        drive(1, 'h010, 1, 1, 0, 0, 20, "R10");
        // random traffic; max_idx varies on the access cycle
        for (int i = 0; i < 3000; i++) begin
            int a = int'($urandom_range(0, 4095));
            if ($urandom_range(0, 7) != 0) a = a & ~3;
            drive($urandom_range(0, 5) != 0, a, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), int'($urandom_range(0, 63)), "");
        end
        drive(0, 0, 0, 0, 0, 0, 0, "");
        drive(0, 0, 0, 0, 0, 0, 0, "");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule